// File: doc/BRIEF.md
# Lockable Clock Channel Control Bank

This block holds one control word for each peripheral clock channel in a bank of 46 channels. Each word picks which of nine clock generators feeds the channel. It also holds an enable for the channel and a sticky lock bit. Software reaches the words through a plain memory-mapped register port: a select, a write strobe, an address, write data, and read data that follows the address combinationally. The words sit at byte address 0x80 + 4*m.

When a channel's lock bit is set, the word can no longer be changed, and a user reset does not clear it. The lock also marks the generator named by that word as locked, which the block reports on a per-generator vector. Generator 0 is the one exception: it is never marked. Only a power reset removes a lock. A user reset clears only the channels that are unlocked.

The enable of each channel is carried into the generator clock domain through a two-flop synchroniser. The synchronised value is then carried back into the bus domain. The enable bit that software reads back is that returned value, so a read keeps showing the old enable until the handshake has finished.

Top module: `clk_chan_bank`

## Requirements
- R1: Channel m (0..45) is read and written at byte address 0x80 + 4*m. In the word, bits 3:0 hold the generator select, bit 6 holds the enable and bit 7 holds the lock. All other bits read as 0. A write to any other address, an unaligned one included, changes nothing, and a read of such an address returns 0.
- R2: While the power reset `por_n` is low, every field of every channel is cleared, and so are `ch_gen`, `ch_en_sync` and `gen_locked`.
- R3: A write whose select code is 0x0..0x8 stores that code. A write whose code is 0x9..0xF leaves the stored select unchanged, while the enable and lock fields of the same write are still stored.
- R4: Once a channel's lock bit is 1, every later write to that channel is ignored until a power reset. The write that sets the lock also stores its own select and enable.
- R5: `gen_locked[n]` is 1 for n in 1..8 exactly when some locked channel selects generator n. `gen_locked[0]` is always 0.
- R6: A cycle with `usr_rst` high clears the select and enable of every unlocked channel. A locked channel keeps all of its fields, and no lock bit is changed by a user reset.
- R7: `ch_en_sync[m]` follows the stored enable after a two-flop synchroniser clocked by `gclk`. Read bit 6 keeps its old value until that synchronised value has been returned to the bus domain, so it has not changed in the first cycle after the write.
- R8: Channel 39 is reserved. It reads as 0, ignores writes, drives 0 on its outputs and never sets a `gen_locked` bit.
- R9: `ch_gen[4*m+3:4*m]` shows channel m's stored select from the cycle after the write that stored it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-domain clock |
| gclk | input | 1 | Generator-domain clock for the enable synchronisers |
| por_n | input | 1 | Power reset, asynchronous, active low |
| usr_rst | input | 1 | User reset, synchronous to clk, active high |
| bus_sel | input | 1 | Register access select |
| bus_we | input | 1 | Write strobe, qualified by bus_sel |
| bus_addr | input | 10 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| ch_gen | output | 184 | Generator select per channel, 4 bits each |
| ch_en_sync | output | 46 | Channel enable in the generator domain |
| gen_locked | output | 9 | Per-generator locked flags |

## Verification
The bench writes every channel in turn. For each one it checks the select output, the field masking and the lagging enable readback. A design that exposed the enable at once, or that ignored bit 6, would fail there. The bench also sweeps all seven reserved select codes: a design that stored them would show codes above 8.

It locks one channel on generator 3 and another on generator 0. It expects only bit 3 of the locked vector, so a design that marks generator 0 is caught. It then attacks the locked word with writes and a user reset. A design whose lock is not sticky, or whose user reset clears everything, would show changed words.

Finally it applies a power reset and expects every lock gone and the channel writable again. It also probes reserved channel 39, out-of-range addresses and unaligned addresses, where a loose decoder would alias onto a real channel.

// File: rtl/clk_chan_pkg.sv
package clk_chan_pkg;
  localparam int GEN_W   = 4;
  localparam int WORD_W  = 32;
  localparam int BIT_EN  = 6;
  localparam int BIT_LCK = 7;

  // Byte address of channel m, and whether this access hits it.
  function automatic logic chan_hit(input int unsigned addr, input int unsigned base,
                                    input int unsigned m, input int unsigned rsvd);
    return (addr == base + 4 * m) && (m != rsvd);
  endfunction

  // Select codes below the generator count are legal.
  function automatic logic gen_code_ok(input logic [GEN_W-1:0] code, input int unsigned ngen);
    return 32'(code) < ngen;
  endfunction

  // Build the readback word from its fields.
  function automatic logic [WORD_W-1:0] pack_word(input logic [GEN_W-1:0] gen,
                                                  input logic en, input logic lck);
    logic [WORD_W-1:0] w;
    w = '0;
    w[GEN_W-1:0] = gen;
    w[BIT_EN]    = en;
    w[BIT_LCK]   = lck;
    return w;
  endfunction
endpackage

// File: rtl/chan_reg.sv
module chan_reg
  import clk_chan_pkg::*;
#(
  parameter int NGEN = 9
) (
  input  logic             clk,
  input  logic             por_n,
  input  logic             usr_rst,
  input  logic             wr,
  input  logic [GEN_W-1:0] gen_in,
  input  logic             en_in,
  input  logic             lock_in,
  output logic [GEN_W-1:0] gen_q,
  output logic             en_q,
  output logic             lock_q
);
  // Named events for the assertions.
  logic wr_take;
  logic gen_take;
  logic usr_clear;

  assign usr_clear = usr_rst && !lock_q;
  assign wr_take   = wr && !lock_q && !usr_rst;
  assign gen_take  = wr_take && gen_code_ok(gen_in, NGEN);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      gen_q  <= '0;
      en_q   <= 1'b0;
      lock_q <= 1'b0;
    end else if (usr_clear) begin
      gen_q  <= '0;
      en_q   <= 1'b0;
    end else if (wr_take) begin
      if (gen_take) gen_q <= gen_in;
      en_q   <= en_in;
      lock_q <= lock_in;
    end
  end

  AST_LOCK_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
    lock_q |=> ($stable(gen_q) && $stable(en_q))); // R4
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    lock_q |=> lock_q); // R6
  AST_GEN_LEGAL: assert property (@(posedge clk) disable iff (!por_n)
    32'(gen_q) < NGEN); // R3
  AST_USR_CLEARS: assert property (@(posedge clk) disable iff (!por_n)
    (usr_rst && !lock_q) |=> (gen_q == '0 && !en_q && !lock_q)); // R6
endmodule

// File: rtl/chan_en_cdc.sv
module chan_en_cdc #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic gclk,
  input  logic rst_n,
  input  logic en_req,
  output logic en_g,
  output logic en_ack
);
  logic [STAGES-1:0] g_pipe;
  logic [STAGES-1:0] b_pipe;

  always_ff @(posedge gclk or negedge rst_n) begin
    if (!rst_n) g_pipe <= '0;
    else        g_pipe <= {g_pipe[STAGES-2:0], en_req};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) b_pipe <= '0;
    else        b_pipe <= {b_pipe[STAGES-2:0], g_pipe[STAGES-1]};
  end

  assign en_g   = g_pipe[STAGES-1];
  assign en_ack = b_pipe[STAGES-1];
endmodule

// File: rtl/gen_lock_map.sv
module gen_lock_map
  import clk_chan_pkg::*;
#(
  parameter int NCH  = 46,
  parameter int NGEN = 9
) (
  input  logic [NCH*GEN_W-1:0] gen_flat,
  input  logic [NCH-1:0]       lock_vec,
  output logic [NGEN-1:0]      gen_locked
);
  assign gen_locked[0] = 1'b0;

  for (genvar n = 1; n < NGEN; n++) begin : g_gen
    logic [NCH-1:0] match;
    for (genvar m = 0; m < NCH; m++) begin : g_ch
      assign match[m] = lock_vec[m] && (gen_flat[m*GEN_W +: GEN_W] == GEN_W'(n));
    end
    assign gen_locked[n] = |match;
  end
endmodule

// File: rtl/clk_chan_bank.sv
module clk_chan_bank
  import clk_chan_pkg::*;
#(
  parameter int NCH       = 46,
  parameter int NGEN      = 9,
  parameter int RSVD_CH   = 39,
  parameter int BASE_ADDR = 'h80,
  parameter int AW        = 10
) (
  input  logic                 clk,
  input  logic                 gclk,
  input  logic                 por_n,
  input  logic                 usr_rst,
  input  logic                 bus_sel,
  input  logic                 bus_we,
  input  logic [AW-1:0]        bus_addr,
  input  logic [WORD_W-1:0]    bus_wdata,
  output logic [WORD_W-1:0]    bus_rdata,
  output logic [NCH*GEN_W-1:0] ch_gen,
  output logic [NCH-1:0]       ch_en_sync,
  output logic [NGEN-1:0]      gen_locked
);
  logic                  wr_strobe;
  logic [NCH-1:0]        hit;
  logic [NCH-1:0]        lock_vec;
  logic [NCH-1:0]        en_req;
  logic [NCH-1:0]        en_ack;
  logic [NCH-1:0]        ch_busy;
  logic [WORD_W-1:0]     word   [NCH];
  logic [WORD_W-1:0]     rd_sel [NCH];
  logic                  unused_wdata;

  assign wr_strobe    = bus_sel && bus_we;
  assign unused_wdata = ^{bus_wdata[WORD_W-1:BIT_LCK+1], bus_wdata[BIT_EN-1:GEN_W]};

  for (genvar m = 0; m < NCH; m++) begin : g_ch
    if (m == RSVD_CH) begin : g_rsvd
      assign hit[m]                  = 1'b0;
      assign lock_vec[m]             = 1'b0;
      assign en_req[m]               = 1'b0;
      assign en_ack[m]               = 1'b0;
      assign ch_en_sync[m]           = 1'b0;
      assign ch_gen[m*GEN_W +: GEN_W] = '0;
    end else begin : g_live
      logic [GEN_W-1:0] gen_q;
      assign hit[m] = chan_hit(32'(bus_addr), BASE_ADDR, m, RSVD_CH);

      chan_reg #(.NGEN(NGEN)) u_reg (
        .clk     (clk),
        .por_n   (por_n),
        .usr_rst (usr_rst),
        .wr      (wr_strobe && hit[m]),
        .gen_in  (bus_wdata[GEN_W-1:0]),
        .en_in   (bus_wdata[BIT_EN]),
        .lock_in (bus_wdata[BIT_LCK]),
        .gen_q   (gen_q),
        .en_q    (en_req[m]),
        .lock_q  (lock_vec[m])
      );

      chan_en_cdc #(.STAGES(2)) u_cdc (
        .clk    (clk),
        .gclk   (gclk),
        .rst_n  (por_n),
        .en_req (en_req[m]),
        .en_g   (ch_en_sync[m]),
        .en_ack (en_ack[m])
      );

      assign ch_gen[m*GEN_W +: GEN_W] = gen_q;
    end
    assign ch_busy[m] = en_req[m] ^ en_ack[m];
    assign word[m]    = pack_word(ch_gen[m*GEN_W +: GEN_W], en_ack[m], lock_vec[m]);
  end

  // Readback: OR of the word gated by its hit; at most one hit is live.
  always_comb begin
    bus_rdata = '0;
    for (int m = 0; m < NCH; m++) begin
      rd_sel[m] = hit[m] ? word[m] : '0;
      bus_rdata = bus_rdata | rd_sel[m];
    end
  end

  gen_lock_map #(.NCH(NCH), .NGEN(NGEN)) u_map (
    .gen_flat   (ch_gen),
    .lock_vec   (lock_vec),
    .gen_locked (gen_locked)
  );

  AST_GEN0_NEVER_LOCKED: assert property (@(posedge clk) disable iff (!por_n)
    !gen_locked[0]); // R5
  AST_ONE_HIT: assert property (@(posedge clk) disable iff (!por_n)
    $onehot0(hit)); // R1
  AST_RSVD_SILENT: assert property (@(posedge clk) disable iff (!por_n)
    (32'(bus_addr) == BASE_ADDR + 4 * RSVD_CH) |-> (bus_rdata == '0)); // R8
  AST_IDLE_READS_SETTLED: assert property (@(posedge clk) disable iff (!por_n)
    (hit != '0 && (hit & ch_busy) == '0) |-> (bus_rdata[BIT_EN] == |(hit & en_req))); // R7
endmodule

// File: tb/clk_chan_bank_bench.sv
module clk_chan_bank_bench;
  localparam int NCH = 46;
  localparam int RS  = 39;

  logic        clk = 0, gclk = 0, por_n = 0, usr_rst = 0;
  logic        bus_sel = 0, bus_we = 0;
  logic [9:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [183:0] ch_gen;
  logic [45:0]  ch_en_sync;
  logic [8:0]   gen_locked;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [3:0] e_gen [NCH];
  logic       e_en  [NCH];
  logic       e_lck [NCH];

  always #5 clk = ~clk;
  always #7 gclk = ~gclk;

  clk_chan_bank u_clk_chan_bank (
    .clk(clk), .gclk(gclk), .por_n(por_n), .usr_rst(usr_rst),
    .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ch_gen(ch_gen), .ch_en_sync(ch_en_sync), .gen_locked(gen_locked)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr_addr(input logic [9:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_we = 0;
  endtask

  // Apply the requirement rules to the bench model, then drive the write.
  task automatic wr_ch(input int m, input logic [31:0] d);
    if (m != RS && !e_lck[m]) begin
      if (d[3:0] <= 4'd8) e_gen[m] = d[3:0];
      e_en[m]  = d[6];
      e_lck[m] = d[7];
    end
    wr_addr(10'(32'h80 + 4 * m), d);
  endtask

  task automatic rd_addr(input logic [9:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] exp_word(input int m);
    return {24'd0, e_lck[m], e_en[m], 2'b00, e_gen[m]};
  endfunction

  function automatic logic [8:0] exp_locked();
    logic [8:0] v = '0;
    for (int m = 0; m < NCH; m++)
      if (e_lck[m] && e_gen[m] != 0) v[e_gen[m]] = 1'b1;
    return v;
  endfunction

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    logic [31:0] d;
    for (int m = 0; m < NCH; m++) begin
      rd_addr(10'(32'h80 + 4 * m), d);
      chk(d == exp_word(m), tag, d, exp_word(m));
    end
    chk(gen_locked == exp_locked(), {tag, " R5 locked vector"}, 32'(gen_locked), 32'(exp_locked()));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    for (int m = 0; m < NCH; m++) begin e_gen[m] = 0; e_en[m] = 0; e_lck[m] = 0; end
    repeat (3) @(negedge clk);
    // R2: reset state
    chk(ch_gen == '0 && ch_en_sync == '0 && gen_locked == '0, "R2 outputs in reset",
        32'(ch_en_sync), 32'd0);
    por_n = 1;
    check_all("R2 reset words");

    // Sweep: write every channel, with junk in bits 5:4 and 31:8.
    for (int m = 0; m < NCH; m++) begin
      wr_ch(m, 32'hABCD_0030 | 32'(m % 9) | ((m % 2 == 1) ? 32'h40 : 32'h0));
      chk(ch_gen[m*4 +: 4] == e_gen[m], "R9 ch_gen after write", 32'(ch_gen[m*4 +: 4]), 32'(e_gen[m]));
      rd_addr(10'(32'h80 + 4 * m), d);
      chk(d[6] == 1'b0, "R7 enable readback still old", 32'(d[6]), 32'd0);
      chk(d[5:0] == {2'b00, e_gen[m]} && d[31:8] == '0, "R1 R8 field layout", d, {26'd0, 2'b00, e_gen[m]});
    end
    settle();
    for (int m = 0; m < NCH; m++)
      chk(ch_en_sync[m] == e_en[m], "R7 synchronised enable", 32'(ch_en_sync[m]), 32'(e_en[m]));
    check_all("R1 R7 settled words");

    // R1: out-of-range and unaligned accesses
    wr_addr(10'h081, 32'h0000_0048);
    wr_addr(10'h07C, 32'h0000_0048);
    wr_addr(10'(32'h80 + 4 * NCH), 32'h0000_0048);
    rd_addr(10'h07C, d);
    chk(d == 0, "R1 read below base", d, 0);
    rd_addr(10'(32'h80 + 4 * NCH), d);
    chk(d == 0, "R1 read past end", d, 0);
    rd_addr(10'h081, d);
    chk(d == 0, "R1 unaligned read", d, 0);
    settle();
    check_all("R1 stray writes ignored");

    // R3: reserved select codes keep the select
    for (int c = 9; c < 16; c++) begin
      wr_ch(2, 32'h40 | 32'(c));
      chk(ch_gen[2*4 +: 4] == 4'd2, "R3 reserved code kept select", 32'(ch_gen[2*4 +: 4]), 32'd2);
    end
    settle();
    check_all("R3 enable still written");

    // R4 R5: locks
    wr_ch(10, 32'h83);
    chk(gen_locked == 9'b0_0000_1000, "R5 generator 3 locked", 32'(gen_locked), 32'h8);
    wr_ch(11, 32'h80);
    chk(gen_locked == 9'b0_0000_1000, "R5 generator 0 never locked", 32'(gen_locked), 32'h8);
    wr_ch(10, 32'h45);
    chk(ch_gen[10*4 +: 4] == 4'd3, "R4 locked select held", 32'(ch_gen[10*4 +: 4]), 32'd3);
    wr_ch(11, 32'h07);
    wr_ch(RS, 32'hC7);
    rd_addr(10'(32'h80 + 4 * RS), d);
    chk(d == 0, "R8 reserved channel reads zero", d, 0);
    chk(gen_locked == 9'b0_0000_1000, "R8 reserved channel lock ignored", 32'(gen_locked), 32'h8);
    settle();
    check_all("R4 locked words unchanged");

    // R6: user reset
    @(negedge clk); usr_rst = 1;
    @(negedge clk); usr_rst = 0;
    for (int m = 0; m < NCH; m++)
      if (!e_lck[m]) begin e_gen[m] = 0; e_en[m] = 0; end
    chk(ch_gen[13*4 +: 4] == 4'd0, "R6 unlocked select cleared", 32'(ch_gen[13*4 +: 4]), 0);
    chk(ch_gen[10*4 +: 4] == 4'd3, "R6 locked select kept", 32'(ch_gen[10*4 +: 4]), 3);
    settle();
    chk(ch_en_sync == '0, "R6 enables cleared after sync", 32'(ch_en_sync), 0);
    check_all("R6 after user reset");

    // R2 R4: power reset removes locks
    @(negedge clk); por_n = 0;
    @(negedge clk);
    for (int m = 0; m < NCH; m++) begin e_gen[m] = 0; e_en[m] = 0; e_lck[m] = 0; end
    chk(gen_locked == '0 && ch_gen == '0, "R2 power reset clears", 32'(gen_locked), 0);
    por_n = 1;
    wr_ch(10, 32'h45);
    chk(ch_gen[10*4 +: 4] == 4'd5, "R4 writable after power reset", 32'(ch_gen[10*4 +: 4]), 5);
    settle();
    check_all("R2 after power reset");

    finish_run();
  end
endmodule